// File: doc/BRIEF.md
# Burst-of-four late-write SRAM model

This block is a synthesizable model of a double-data-rate SRAM with one shared data path and a fixed burst of four words. All control runs on a single system clock. Each double-rate transfer is carried as two lanes per clock cycle. The rise lane stands for the beat of the rising phase, and the fall lane stands for the beat of the falling phase. A read or write command, with its word address, is sampled on the rising edge. Every accepted command then keeps the block busy for one more cycle.

Write data is posted. Beats arrive in the two cycles after the command and are collected in a one-entry buffer. The buffer is copied into the array only when the next write command is accepted. Reads look through that buffer byte by byte, so software always sees its latest write.

Read data comes back on a fixed schedule, with one echo-valid flag per lane. The stream has no back-pressure. A consumer must take each beat in the cycle in which its valid flag is high, because the block can neither stall nor repeat a beat.

Top module: `burst4_lw_sram`

## Requirements
- R1: While reset is low and in the first cycle after it, both valid flags, both read lanes and `proto_err` are 0.
- R2: A command is sampled only on a rising edge in an idle cycle. Read is `cmd_rd`=1 with `cmd_wr`=0, and write is the reverse. The cycle after an accepted command is busy, and `addr` is ignored in every cycle that carries no accepted command.
- R3: A command in a busy cycle, or `cmd_rd` and `cmd_wr` high together, is ignored and sets `proto_err`. The flag stays at 1 until reset.
- R4: Beat k (k=0..3) of a burst uses word address {addr[ADDR_W-1:2], (addr[1:0]+k) mod 4}, which wraps inside the aligned group of four words.
- R5: For a write sampled at edge E, beats 0 and 1 are taken from the rise and fall lanes at edge E+1, and beats 2 and 3 are taken from the rise and fall lanes at edge E+2.
- R6: Bit b of a byte-enable lane is sampled with the data of the same lane and beat. At 1 it updates bits [8b+7:8b] of that word, and at 0 it leaves them unchanged.
- R7: For a read sampled at edge E, beat 0 is on `rdata_fall` after E+1. Beats 1 and 2 are on `rdata_rise` and `rdata_fall` after E+2. Beat 3 is on `rdata_rise` after E+3.
- R8: Each valid flag is 1 exactly in the cycles its lane carries a read beat. A lane that carries no beat reads 0.
- R9: A read returns the latest written bytes, including those of a write still held in the posted buffer. This holds even when the read is issued straight after the write's last data cycle.
- R10: Reads issued every other cycle produce a gap-free beat stream on the two lanes.
- R11: After reset, every word reads as 0 until it is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; rising edge samples commands |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_rd | input | 1 | Read command request |
| cmd_wr | input | 1 | Write command request |
| addr | input | ADDR_W | Word address of the first beat |
| wdata_rise | input | DATA_W | Write beat of the rising phase |
| wdata_fall | input | DATA_W | Write beat of the falling phase |
| wbe_rise | input | DATA_W/8 | Byte enables for `wdata_rise` |
| wbe_fall | input | DATA_W/8 | Byte enables for `wdata_fall` |
| rdata_rise | output | DATA_W | Read beat of the rising phase |
| rdata_fall | output | DATA_W | Read beat of the falling phase |
| rvalid_rise | output | 1 | Echo valid for `rdata_rise` |
| rvalid_fall | output | 1 | Echo valid for `rdata_fall` |
| proto_err | output | 1 | Sticky protocol-violation flag |

## Verification
The bench targets three cases.

The first is a read issued in the same cycle as the last data beats of a write to the same group of four words. A design that looks up its buffer too early returns stale bytes.

The second is a write issued in the same cycle as the previous write's last beats. A design that commits the buffer before merging those beats loses half of the earlier burst. A following read then shows it.

The third is a set of bursts that start at unaligned offsets and carry partial byte enables. These expose a wrong wrap order or a mask applied to the wrong beat. Busy-cycle and conflicting commands are also sent. A design that accepted them would emit unexpected valid beats, or would leave `proto_err` low.

// File: rtl/bls_pkg.sv
package bls_pkg;
  localparam int BURST_LEN = 4;
  localparam int SLOT_W    = 2;
  localparam int BYTE_W    = 8;

  typedef logic [SLOT_W-1:0] slot_t;

  // word position inside the aligned group for beat k of a burst
  function automatic slot_t slot_of(input slot_t base, input int unsigned k);
    return base + slot_t'(k);
  endfunction
endpackage

// File: rtl/bls_cmd_ctrl.sv
module bls_cmd_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_rd,
  input  logic cmd_wr,
  output logic acc_rd,
  output logic acc_wr,
  output logic wr_ph1,
  output logic wr_ph2,
  output logic proto_err
);
  logic busy_q, ph1_q, ph2_q, err_q;
  logic any_cmd, clash, bad_cmd;

  assign any_cmd = cmd_rd | cmd_wr;
  assign clash   = cmd_rd & cmd_wr;
  assign acc_rd  = ~busy_q & cmd_rd & ~cmd_wr;
  assign acc_wr  = ~busy_q & cmd_wr & ~cmd_rd;
  assign bad_cmd = any_cmd & (busy_q | clash);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ph1_q  <= 1'b0;
      ph2_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      busy_q <= acc_rd | acc_wr;
      ph1_q  <= acc_wr;
      ph2_q  <= ph1_q;
      err_q  <= err_q | bad_cmd;
    end
  end

  assign wr_ph1    = ph1_q;
  assign wr_ph2    = ph2_q;
  assign proto_err = err_q;

  AST_CMD_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd || acc_wr) |=> !(acc_rd || acc_wr)); // R2
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err); // R3
endmodule

// File: rtl/bls_wbuf.sv
module bls_wbuf
  import bls_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BLK_W  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic acc_wr,
  input  logic [BLK_W-1:0] in_blk,
  input  slot_t in_off,
  input  logic wr_ph1,
  input  logic wr_ph2,
  input  logic [DATA_W-1:0] wd_rise,
  input  logic [DATA_W-1:0] wd_fall,
  input  logic [DATA_W/BYTE_W-1:0] wb_rise,
  input  logic [DATA_W/BYTE_W-1:0] wb_fall,
  input  logic [BLK_W-1:0] look_blk,
  input  logic [BURST_LEN-1:0][DATA_W-1:0] mem_row,
  output logic [BURST_LEN-1:0][DATA_W-1:0] merged_row,
  output logic commit_en,
  output logic [BLK_W-1:0] commit_blk,
  output logic [BURST_LEN-1:0][DATA_W-1:0] commit_row,
  output logic [BURST_LEN-1:0][DATA_W/BYTE_W-1:0] commit_mask
);
  localparam int NB = DATA_W / BYTE_W;

  logic bvalid;
  logic [BLK_W-1:0] bblk;
  slot_t boff;
  logic [BURST_LEN-1:0][DATA_W-1:0] bdata, nx_data;
  logic [BURST_LEN-1:0][NB-1:0] bbe, nx_be;
  logic hit;

  // buffer contents including the beats arriving this cycle
  always_comb begin
    nx_data = bdata;
    nx_be   = bbe;
    for (int j = 0; j < BURST_LEN; j++) begin
      if (wr_ph1 && slot_of(boff, 0) == slot_t'(j)) begin
        nx_data[j] = wd_rise;
        nx_be[j]   = wb_rise;
      end
      if (wr_ph1 && slot_of(boff, 1) == slot_t'(j)) begin
        nx_data[j] = wd_fall;
        nx_be[j]   = wb_fall;
      end
      if (wr_ph2 && slot_of(boff, 2) == slot_t'(j)) begin
        nx_data[j] = wd_rise;
        nx_be[j]   = wb_rise;
      end
      if (wr_ph2 && slot_of(boff, 3) == slot_t'(j)) begin
        nx_data[j] = wd_fall;
        nx_be[j]   = wb_fall;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bvalid <= 1'b0;
      bblk   <= '0;
      boff   <= '0;
      bdata  <= '0;
      bbe    <= '0;
    end else if (acc_wr) begin
      bvalid <= 1'b1;
      bblk   <= in_blk;
      boff   <= in_off;
      bbe    <= '0;
    end else begin
      bdata <= nx_data;
      bbe   <= nx_be;
    end
  end

  assign commit_en   = acc_wr & bvalid;
  assign commit_blk  = bblk;
  assign commit_row  = nx_data;
  assign commit_mask = nx_be;

  assign hit = bvalid && (look_blk == bblk);

  for (genvar j = 0; j < BURST_LEN; j++) begin : g_word
    for (genvar b = 0; b < NB; b++) begin : g_byte
      assign merged_row[j][b*BYTE_W +: BYTE_W] = (hit && bbe[j][b]) ?
        bdata[j][b*BYTE_W +: BYTE_W] : mem_row[j][b*BYTE_W +: BYTE_W];
    end
  end

  AST_FILL_APART_FROM_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ph1 |-> !acc_wr); // R5
  AST_BUFFER_RETAINED: assert property (@(posedge clk) disable iff (!rst_n)
    bvalid |=> bvalid); // R9
endmodule

// File: rtl/bls_array.sv
module bls_array
  import bls_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BLK_W  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic [BLK_W-1:0] wr_blk,
  input  logic [BURST_LEN-1:0][DATA_W-1:0] wr_row,
  input  logic [BURST_LEN-1:0][DATA_W/BYTE_W-1:0] wr_mask,
  input  logic [BLK_W-1:0] rd_blk,
  output logic [BURST_LEN-1:0][DATA_W-1:0] rd_row
);
  localparam int NB    = DATA_W / BYTE_W;
  localparam int DEPTH = 1 << BLK_W;

  logic [BURST_LEN-1:0][DATA_W-1:0] rows [DEPTH];

  for (genvar r = 0; r < DEPTH; r++) begin : g_row
    logic [BURST_LEN-1:0][DATA_W-1:0] row_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        row_q <= '0;
      end else if (wr_en && wr_blk == BLK_W'(r)) begin
        for (int j = 0; j < BURST_LEN; j++) begin
          for (int b = 0; b < NB; b++) begin
            if (wr_mask[j][b]) row_q[j][b*BYTE_W +: BYTE_W] <= wr_row[j][b*BYTE_W +: BYTE_W];
          end
        end
      end
    end
    assign rows[r] = row_q;
  end

  assign rd_row = rows[rd_blk];
endmodule

// File: rtl/bls_rd_pipe.sv
module bls_rd_pipe
  import bls_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BLK_W  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic acc_rd,
  input  logic [BLK_W-1:0] in_blk,
  input  slot_t in_off,
  input  logic [BURST_LEN-1:0][DATA_W-1:0] row_in,
  output logic [BLK_W-1:0] look_blk,
  output logic [DATA_W-1:0] rdata_rise,
  output logic [DATA_W-1:0] rdata_fall,
  output logic rvalid_rise,
  output logic rvalid_fall
);
  logic st1, st2, st3;
  logic [BLK_W-1:0] blk_a;
  slot_t off_a, off_b;
  logic [BURST_LEN-1:0][DATA_W-1:0] rrow;

  assign look_blk = blk_a;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st1 <= 1'b0;
      st2 <= 1'b0;
      st3 <= 1'b0;
      blk_a <= '0;
      off_a <= '0;
      off_b <= '0;
      rrow  <= '0;
      rdata_rise  <= '0;
      rdata_fall  <= '0;
      rvalid_rise <= 1'b0;
      rvalid_fall <= 1'b0;
    end else begin
      st1 <= acc_rd;
      st2 <= st1;
      st3 <= st2;
      if (acc_rd) begin
        blk_a <= in_blk;
        off_a <= in_off;
      end
      if (st1) begin
        rrow  <= row_in;
        off_b <= off_a;
      end
      rvalid_fall <= st1 | st2;
      rvalid_rise <= st2 | st3;
      if (st1)      rdata_fall <= row_in[slot_of(off_a, 0)];
      else if (st2) rdata_fall <= rrow[slot_of(off_b, 2)];
      else          rdata_fall <= '0;
      if (st2)      rdata_rise <= rrow[slot_of(off_b, 1)];
      else if (st3) rdata_rise <= rrow[slot_of(off_b, 3)];
      else          rdata_rise <= '0;
    end
  end

  AST_FIRST_BEAT_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rd |-> ##2 rvalid_fall); // R7
  AST_RISE_BEATS_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rvalid_rise) |=> rvalid_rise); // R10
endmodule

// File: rtl/burst4_lw_sram.sv
module burst4_lw_sram
  import bls_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_rd,
  input  logic cmd_wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata_rise,
  input  logic [DATA_W-1:0] wdata_fall,
  input  logic [DATA_W/8-1:0] wbe_rise,
  input  logic [DATA_W/8-1:0] wbe_fall,
  output logic [DATA_W-1:0] rdata_rise,
  output logic [DATA_W-1:0] rdata_fall,
  output logic rvalid_rise,
  output logic rvalid_fall,
  output logic proto_err
);
  localparam int NB    = DATA_W / BYTE_W;
  localparam int BLK_W = ADDR_W - SLOT_W;

  logic acc_rd, acc_wr, wr_ph1, wr_ph2;
  logic [BLK_W-1:0] in_blk, look_blk, cm_blk;
  slot_t in_off;
  logic [BURST_LEN-1:0][DATA_W-1:0] arr_row, mrg_row, cm_row;
  logic [BURST_LEN-1:0][NB-1:0] cm_mask;
  logic cm_en;

  assign in_blk = addr[ADDR_W-1:SLOT_W];
  assign in_off = addr[SLOT_W-1:0];

  bls_cmd_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr),
    .acc_rd(acc_rd), .acc_wr(acc_wr), .wr_ph1(wr_ph1), .wr_ph2(wr_ph2),
    .proto_err(proto_err)
  );

  bls_wbuf #(.DATA_W(DATA_W), .BLK_W(BLK_W)) u_wbuf (
    .clk(clk), .rst_n(rst_n), .acc_wr(acc_wr), .in_blk(in_blk), .in_off(in_off),
    .wr_ph1(wr_ph1), .wr_ph2(wr_ph2),
    .wd_rise(wdata_rise), .wd_fall(wdata_fall), .wb_rise(wbe_rise), .wb_fall(wbe_fall),
    .look_blk(look_blk), .mem_row(arr_row), .merged_row(mrg_row),
    .commit_en(cm_en), .commit_blk(cm_blk), .commit_row(cm_row), .commit_mask(cm_mask)
  );

  bls_array #(.DATA_W(DATA_W), .BLK_W(BLK_W)) u_array (
    .clk(clk), .rst_n(rst_n), .wr_en(cm_en), .wr_blk(cm_blk), .wr_row(cm_row),
    .wr_mask(cm_mask), .rd_blk(look_blk), .rd_row(arr_row)
  );

  bls_rd_pipe #(.DATA_W(DATA_W), .BLK_W(BLK_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .acc_rd(acc_rd), .in_blk(in_blk), .in_off(in_off),
    .row_in(mrg_row), .look_blk(look_blk),
    .rdata_rise(rdata_rise), .rdata_fall(rdata_fall),
    .rvalid_rise(rvalid_rise), .rvalid_fall(rvalid_fall)
  );
endmodule

// File: tb/burst4_lw_sram_test.sv
module burst4_lw_sram_test;
  localparam int DW = 16;
  localparam int AW = 6;
  localparam int NB = DW / 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_rd = 1'b0, cmd_wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata_rise = '0, wdata_fall = '0;
  logic [NB-1:0] wbe_rise = '0, wbe_fall = '0;
  logic [DW-1:0] rdata_rise, rdata_fall;
  logic rvalid_rise, rvalid_fall, proto_err;

  always #4 clk = ~clk;

  burst4_lw_sram #(.DATA_W(DW), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr), .addr(addr),
    .wdata_rise(wdata_rise), .wdata_fall(wdata_fall), .wbe_rise(wbe_rise), .wbe_fall(wbe_fall),
    .rdata_rise(rdata_rise), .rdata_fall(rdata_fall),
    .rvalid_rise(rvalid_rise), .rvalid_fall(rvalid_fall), .proto_err(proto_err)
  );

  // behavioural reference
  logic [DW-1:0] mm [1<<AW];
  logic [DW-1:0] exr [int];
  logic [DW-1:0] exf [int];
  int cyc = 0;
  int wst = 0;
  bit busy_m = 0, err_m = 0, done = 0;
  logic [AW-1:0] wad;
  string tag = "R1";
  int checks = 0, errors = 0;

  function automatic logic [AW-1:0] wi(input logic [AW-1:0] a, input int k);
    logic [1:0] s;
    s = a[1:0] + 2'(k);
    return {a[AW-1:2], s};
  endfunction

  function automatic logic [DW-1:0] mrg(input logic [DW-1:0] o, input logic [DW-1:0] n,
                                        input logic [NB-1:0] be);
    logic [DW-1:0] r;
    r = o;
    for (int b = 0; b < NB; b++) if (be[b]) r[b*8 +: 8] = n[b*8 +: 8];
    return r;
  endfunction

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (!rst_n) begin
      wst = 0; busy_m = 0; err_m = 0;
      exr.delete(); exf.delete();
      for (int i = 0; i < (1<<AW); i++) mm[i] = '0;
    end else begin
      if (wst == 1) begin
        mm[wi(wad,0)] = mrg(mm[wi(wad,0)], wdata_rise, wbe_rise);
        mm[wi(wad,1)] = mrg(mm[wi(wad,1)], wdata_fall, wbe_fall);
        wst = 2;
      end else if (wst == 2) begin
        mm[wi(wad,2)] = mrg(mm[wi(wad,2)], wdata_rise, wbe_rise);
        mm[wi(wad,3)] = mrg(mm[wi(wad,3)], wdata_fall, wbe_fall);
        wst = 0;
      end
      if (cmd_rd || cmd_wr) begin
        if (busy_m || (cmd_rd && cmd_wr)) begin
          err_m = 1; busy_m = 0;
        end else begin
          busy_m = 1;
          if (cmd_wr) begin
            wst = 1; wad = addr;
          end else begin
            exf[cyc+1] = mm[wi(addr,0)];
            exr[cyc+2] = mm[wi(addr,1)];
            exf[cyc+2] = mm[wi(addr,2)];
            exr[cyc+3] = mm[wi(addr,3)];
          end
        end
      end else begin
        busy_m = 0;
      end
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h cycle=%0d", req, what, act, exp, cyc);
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    chk(tag, "rvalid_fall", {31'd0, rvalid_fall}, {31'd0, exf.exists(cyc)});
    chk(tag, "rvalid_rise", {31'd0, rvalid_rise}, {31'd0, exr.exists(cyc)});
    chk(tag, "rdata_fall", {16'd0, rdata_fall}, {16'd0, exf.exists(cyc) ? exf[cyc] : 16'd0});
    chk(tag, "rdata_rise", {16'd0, rdata_rise}, {16'd0, exr.exists(cyc) ? exr[cyc] : 16'd0});
    chk("R3", "proto_err", {31'd0, proto_err}, {31'd0, err_m});
  end

  task automatic step(input logic r, input logic w, input logic [AW-1:0] a,
                      input logic [DW-1:0] dr, input logic [DW-1:0] df,
                      input logic [NB-1:0] br, input logic [NB-1:0] bf);
    @(negedge clk);
    cmd_rd = r; cmd_wr = w; addr = a;
    wdata_rise = dr; wdata_fall = df; wbe_rise = br; wbe_fall = bf;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 6'(i * 7 + 3), 16'(i * 4099), 16'(~i), '1, '1);
  endtask

  task automatic rd(input logic [AW-1:0] a);
    step(1, 0, a, '0, '0, '0, '0);
    step(0, 0, ~a, 16'hDEAD, 16'hBEEF, '1, '1);
  endtask

  // data cycles of an already issued write; the last one may carry the next command
  task automatic wr_tail(input logic [4*DW-1:0] wv, input logic [4*NB-1:0] bv,
                         input logic nr, input logic nw, input logic [AW-1:0] na);
    step(0, 0, 6'h2A, wv[0 +: DW], wv[DW +: DW], bv[0 +: NB], bv[NB +: NB]);
    step(nr, nw, na, wv[2*DW +: DW], wv[3*DW +: DW], bv[2*NB +: NB], bv[3*NB +: NB]);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [4*DW-1:0] wv, input logic [4*NB-1:0] bv);
    step(0, 1, a, '0, '0, '0, '0);
    wr_tail(wv, bv, 0, 0, '0);
  endtask

  initial begin
    tag = "R1";
    idle(3);
    @(negedge clk);
    chk("R1", "reset outputs", {rvalid_rise, rvalid_fall, proto_err, rdata_rise, rdata_fall}, '0);
    rst_n = 1'b1;
    idle(1);
    @(negedge clk);
    chk("R1", "post-reset outputs", {rvalid_rise, rvalid_fall, proto_err, rdata_rise, rdata_fall}, '0);

    tag = "R11"; rd(6'd5); idle(4);
    tag = "R5";  wr(6'd8, {16'h4444, 16'h3333, 16'h2222, 16'h1111}, '1); idle(1); rd(6'd8); idle(4);
    tag = "R4";  wr(6'd13, {16'hD004, 16'hC003, 16'hB002, 16'hA001}, '1); idle(1);
    rd(6'd13); rd(6'd14); rd(6'd12); idle(4);
    tag = "R6";  wr(6'd9, {16'h9999, 16'h8888, 16'h7777, 16'h6666}, 8'b11_00_10_01); idle(1);
    rd(6'd8); idle(4);
    tag = "R9";
    step(0, 1, 6'd21, '0, '0, '0, '0);
    wr_tail({16'h5A04, 16'h5A03, 16'h5A02, 16'h5A01}, '1, 1, 0, 6'd20);
    step(0, 0, 6'd0, '0, '0, '0, '0); idle(4);
    step(0, 1, 6'd40, '0, '0, '0, '0);
    wr_tail({16'h4004, 16'h4003, 16'h4002, 16'h4001}, 8'b01_11_10_11, 0, 1, 6'd46);
    wr_tail({16'h4404, 16'h4403, 16'h4402, 16'h4401}, '1, 1, 0, 6'd41);
    step(0, 0, 6'd0, '0, '0, '0, '0);
    rd(6'd44); idle(4);
    tag = "R7";  rd(6'd9); idle(4);
    tag = "R10"; rd(6'd12); rd(6'd40); rd(6'd22); rd(6'd13); idle(4);
    tag = "R2";
    step(0, 1, 6'd33, '0, '0, '0, '0);
    step(0, 0, 6'd1, 16'hABCD, 16'h1234, '1, '1);
    step(0, 0, 6'd2, 16'h5678, 16'h9ABC, '1, '1);
    idle(1); rd(6'd32); idle(4);
    tag = "R8";  idle(6);
    tag = "R3";
    step(1, 0, 6'd30, '0, '0, '0, '0);
    step(1, 0, 6'd31, '0, '0, '0, '0);
    idle(4);
    step(1, 1, 6'd8, '0, '0, '0, '0);
    idle(4);
    rd(6'd13); idle(5);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule